// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer/Event Counter

This block is an up-counter with a reload register. It has three ways to count. In event mode it counts edges on an external input. In timer mode it counts ticks of a prescaled copy of the system clock. In pulse-width mode it makes one measurement: it times the high or low phase of the external input on the prescaled clock, then stops itself and holds the result.

When the count passes its all-ones value, the counter reloads from the reload register. The same event sets a sticky request output and toggles a square-wave output, which therefore runs at half the overflow rate. Software-side logic reaches the block through a count port and a control port.
- A write to the count port always updates the reload register. It also loads the live counter, but only while the counter is stopped.
- A read of the count port returns the live count.

Top module: `oet_timer`

## Requirements
- R1: After a synchronous reset, the control readback is 0x08, the count is 0, the reload register is 0, and both `ovf_req` and `freq_out` are 0.
- R2: The control byte is laid out as follows: bits 2:0 are the prescale select n, bit 3 is the edge select, bit 4 is the run bit, and bits 7:6 are the mode (00 off, 01 event, 10 timer, 11 pulse-width). Bit 5 always reads back 0.
- R3: In timer mode with run set, the count rises by one on each prescaler tick. The prescaler is a 7-bit counter that free-runs from reset. A tick occurs in each cycle where that counter modulo 2^n equals 2^n-1, so one tick every 2^n cycles.
- R4: In event mode with run set, the counter counts rising input edges when the edge select is 0 and falling edges when it is 1. The input first passes through a two-flop synchronizer. The count changes at the third rising clock edge after the input changes.
- R5: Pulse-width mode with run set and edge select 1 works in three steps.
  - A synchronized rising edge starts the measurement. No count is added in the start cycle.
  - While the measurement is active, the count rises by one per prescaler tick.
  - The next falling edge stops the measurement. No count is added in the stop cycle, the run bit clears by itself, and the count is held.
  Edge select 0 swaps the two polarities.
- R6: A count-port write while run is 0 loads both the reload register and the counter. While run is 1 it loads only the reload register.
- R7: An increment from 0xFF loads the counter from the reload register and sets `ovf_req`. `ovf_req` stays set until `ovf_clr` is applied. If a wrap and `ovf_clr` fall in the same cycle, the request stays set.
- R8: `freq_out` toggles once on every wrap and at no other time.
- R9: In mode 00, or with the run bit 0 in any mode, the count does not change except through a count-port write.
- R10: A control write aborts any measurement in progress. With pulse-width mode and run set, the measurement re-arms and waits for a fresh start edge, and the run bit remains 1. A wrap in the same cycle as a running count write reloads the value the reload register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_wr | input | 1 | Count-port write strobe |
| cnt_wdata | input | 8 | Count-port write data |
| cnt_rdata | output | 8 | Live counter value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control readback |
| ext_in | input | 1 | External event / pulse input (asynchronous) |
| ovf_clr | input | 1 | Clears the overflow request |
| ovf_req | output | 1 | Sticky overflow request |
| freq_out | output | 1 | Toggles on each overflow |

## Verification
Two pairs of events can fall in the same clock cycle:
- A wrap and a request clear.
- A wrap and a count write made while the counter runs.

The bench provokes the first pair by holding `ovf_clr` high over a stretch of timer-mode cycles that contains wraps. It provokes the second by issuing running writes on a short period. Each clock, a behavioural model compares the count, control readback, request and square-wave outputs against the design. For these collisions the model expects three things: the request stays set, the counter reloads the older reload value, and the reload register takes the new data.

// File: rtl/oet_pkg.sv
package oet_pkg;
  localparam int SEL_W    = 3;
  localparam int CTL_W    = 8;
  localparam int PS_LSB   = 0;
  localparam int ES_BIT   = 3;
  localparam int RUN_BIT  = 4;
  localparam int RSV_BIT  = 5;
  localparam int MODE_LSB = 6;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h08;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EVT = 2'b01,
    MODE_TMR = 2'b10,
    MODE_PW  = 2'b11
  } oet_mode_e;
endpackage

// File: rtl/oet_prescaler.sv
module oet_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(sel));
  end

  assign tick = ((div_q & mask) == mask);
endmodule

// File: rtl/oet_edge_sync.sv
module oet_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/oet_timer.sv
module oet_timer
  import oet_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr,
  input  logic [CW-1:0]    cnt_wdata,
  output logic [CW-1:0]    cnt_rdata,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             ext_in,
  input  logic             ovf_clr,
  output logic             ovf_req,
  output logic             freq_out
);
  localparam logic [CW-1:0]    CNT_MAX  = {CW{1'b1}};
  localparam logic [CTL_W-1:0] RSV_MASK = ~(CTL_W'(1) << RSV_BIT);

  logic [CTL_W-1:0] ctl_q;
  logic [CW-1:0]    cnt_q, rld_q;
  logic             ovf_q, frq_q, act_q;

  logic [SEL_W-1:0] psel;
  logic             es, run;
  oet_mode_e        mode;
  logic             tick, rise, fall;
  logic             cnt_ev, start_ev, stop_ev, pw_start, pw_stop, inc, wrap;

  assign psel = ctl_q[PS_LSB +: SEL_W];
  assign es   = ctl_q[ES_BIT];
  assign run  = ctl_q[RUN_BIT];
  assign mode = oet_mode_e'(ctl_q[MODE_LSB +: 2]);

  oet_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .sel(psel), .tick(tick)
  );

  oet_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_in), .rise(rise), .fall(fall)
  );

  always_comb begin
    cnt_ev   = es ? fall : rise;
    start_ev = es ? rise : fall;
    stop_ev  = es ? fall : rise;
    pw_start = run && (mode == MODE_PW) && !act_q && start_ev;
    pw_stop  = run && (mode == MODE_PW) &&  act_q && stop_ev;
    unique case (mode)
      MODE_EVT: inc = run && cnt_ev;
      MODE_TMR: inc = run && tick;
      MODE_PW:  inc = run && act_q && !stop_ev && tick;
      default:  inc = 1'b0;
    endcase
    wrap = inc && (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
      cnt_q <= '0;
      rld_q <= '0;
      ovf_q <= 1'b0;
      frq_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      if (wrap)                cnt_q <= rld_q;
      else if (inc)            cnt_q <= cnt_q + 1'b1;
      else if (cnt_wr && !run) cnt_q <= cnt_wdata;

      if (cnt_wr) rld_q <= cnt_wdata;

      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;

      if (wrap) frq_q <= ~frq_q;

      if (ctl_wr) begin
        ctl_q <= ctl_wdata & RSV_MASK;
        act_q <= 1'b0;
      end else if (pw_start) begin
        act_q <= 1'b1;
      end else if (pw_stop) begin
        act_q          <= 1'b0;
        ctl_q[RUN_BIT] <= 1'b0;
      end
    end
  end

  assign cnt_rdata = cnt_q;
  assign ctl_rdata = ctl_q;
  assign ovf_req   = ovf_q;
  assign freq_out  = frq_q;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst) ctl_rdata[RSV_BIT] == 1'b0); // R2
  AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !run) |=> (cnt_rdata == $past(cnt_wdata))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_OFF || !run) && !cnt_wr) |=> $stable(cnt_rdata)); // R9
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ovf_req && cnt_rdata == $past(rld_q))); // R7
  AST_FREQ_ONLY_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(freq_out)); // R8
  AST_PW_SELF_STOP: assert property (@(posedge clk) disable iff (rst)
    (pw_stop && !ctl_wr) |=> (!ctl_rdata[RUN_BIT] && $stable(cnt_rdata))); // R5
  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> !act_q); // R10
endmodule

// File: tb/sim_oet_timer.sv
module sim_oet_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cnt_wr = 0, ctl_wr = 0, ext_in = 0, ovf_clr = 0;
  logic [7:0] cnt_wdata = 0, ctl_wdata = 0;
  logic [7:0] cnt_rdata, ctl_rdata;
  logic       ovf_req, freq_out;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit chk_on = 0;

  // behavioural model state
  int  m_cnt, m_rld, m_pc;
  logic [7:0] m_ctl;
  bit  m_ovf, m_frq, m_act;
  bit  hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  oet_timer u0 (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ext_in(ext_in),
    .ovf_clr(ovf_clr), .ovf_req(ovf_req), .freq_out(freq_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_ctl = 8'h08; m_cnt = 0; m_rld = 0; m_ovf = 0; m_frq = 0; m_act = 0; m_pc = 0;
      hist = {1'b0, 1'b0, 1'b0};
    end else begin
      int  n;
      bit  tk, ri, fa, st, sp, up, wr_ov, run_now;
      n  = m_ctl[2:0];
      tk = ((m_pc % (1 << n)) == ((1 << n) - 1));
      ri = hist[1] && !hist[2];
      fa = !hist[1] && hist[2];
      st = 0; sp = 0; up = 0; wr_ov = 0;
      run_now = m_ctl[4];
      if (run_now) begin
        case (m_ctl[7:6])
          2'b01: up = m_ctl[3] ? fa : ri;
          2'b10: up = tk;
          2'b11: begin
            if (!m_act && (m_ctl[3] ? ri : fa)) st = 1;
            else if (m_act && (m_ctl[3] ? fa : ri)) sp = 1;
            else if (m_act && tk) up = 1;
          end
          default: ;
        endcase
      end
      if (up) begin
        if (m_cnt == 255) begin m_cnt = m_rld; wr_ov = 1; m_frq = !m_frq; end
        else m_cnt = m_cnt + 1;
      end else if (cnt_wr && !run_now) m_cnt = cnt_wdata;
      if (cnt_wr) m_rld = cnt_wdata;
      if (wr_ov) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (ctl_wr) begin m_ctl = ctl_wdata & 8'hDF; m_act = 0; end
      else if (st) m_act = 1;
      else if (sp) begin m_act = 0; m_ctl[4] = 0; end
      hist.push_front(ext_in);
      void'(hist.pop_back());
      m_pc = (m_pc + 1) % 128;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      compared++;
      if ({cnt_rdata, ctl_rdata, ovf_req, freq_out} !== {m_cnt[7:0], m_ctl, m_ovf, m_frq}) begin
        mismatched++;
        $display("FAIL %s: got cnt=%h ctl=%h ovf=%b frq=%b expected cnt=%h ctl=%h ovf=%b frq=%b",
                 cur_req, cnt_rdata, ctl_rdata, ovf_req, freq_out, m_cnt[7:0], m_ctl, m_ovf, m_frq);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [7:0] d);
    cnt_wdata = d; cnt_wr = 1; @(negedge clk); cnt_wr = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wdata = d; ctl_wr = 1; @(negedge clk); ctl_wr = 0;
  endtask

  task automatic pulse(input int lo, input int hi, input bit lvl_first);
    ext_in = lvl_first; cyc(lo); ext_in = !lvl_first; cyc(hi);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] held;
    cyc(3); rst = 0; cyc(1); chk_on = 1;
    cur_req = "R1";
    chk("R1 ctl", ctl_rdata, 8'h08); chk("R1 cnt", cnt_rdata, 8'h00);
    chk("R1 flags", {6'b0, ovf_req, freq_out}, 8'h00);

    cur_req = "R2";
    wr_ctl(8'hFF); chk("R2 bit5", ctl_rdata, 8'hDF);
    wr_ctl(8'h08);

    cur_req = "R6";
    wr_cnt(8'hF0); chk("R6 stopped load", cnt_rdata, 8'hF0);

    cur_req = "R7";
    wr_ctl(8'h90); cyc(40);
    chk("R7 flag", {7'b0, ovf_req}, 8'h01);
    cur_req = "R8"; cyc(20);
    cur_req = "R6";
    held = cnt_rdata; wr_cnt(8'h10); cyc(60);
    cur_req = "R10";
    ovf_clr = 1; cyc(300); ovf_clr = 0;
    for (int k = 0; k < 40; k++) begin wr_cnt(8'(8'hE0 + k)); cyc(k % 5); end
    ovf_clr = 1; cyc(1); ovf_clr = 0; cyc(30);

    cur_req = "R3";
    wr_ctl(8'h00); wr_cnt(8'hF8); wr_ctl(8'h93); cyc(200);
    wr_ctl(8'h00); wr_cnt(8'hFE); wr_ctl(8'h97); cyc(600);

    cur_req = "R4";
    wr_ctl(8'h00); wr_cnt(8'hFA); wr_ctl(8'h50);
    for (int k = 0; k < 12; k++) pulse(1 + k % 4, 2 + k % 3, 1'b0);
    ext_in = 0; cyc(5);
    wr_ctl(8'h58);
    for (int k = 0; k < 10; k++) pulse(3, 1 + k % 5, 1'b0);
    ext_in = 0; cyc(5);

    cur_req = "R9";
    wr_ctl(8'h10); held = cnt_rdata;
    for (int k = 0; k < 6; k++) pulse(3, 3, 1'b0);
    ext_in = 0; cyc(5); chk("R9 off mode", cnt_rdata, held);
    wr_ctl(8'h80); cyc(50); chk("R9 stopped timer", cnt_rdata, held);

    cur_req = "R5";
    wr_cnt(8'h00); ext_in = 0; wr_ctl(8'hD8); cyc(6);
    ext_in = 1; cyc(20); ext_in = 0; cyc(6);
    chk("R5 run cleared", {7'b0, ctl_rdata[4]}, 8'h00);
    held = cnt_rdata;
    pulse(4, 10, 1'b1); ext_in = 0; cyc(6);
    chk("R5 held", cnt_rdata, held);
    wr_cnt(8'h00); ext_in = 1; wr_ctl(8'hD2); cyc(6);
    ext_in = 0; cyc(37); ext_in = 1; cyc(6);
    chk("R5 reversed run cleared", {7'b0, ctl_rdata[4]}, 8'h00);

    cur_req = "R10";
    wr_cnt(8'h00); ext_in = 0; wr_ctl(8'hD8); cyc(4);
    ext_in = 1; cyc(8); wr_ctl(8'hD8); ext_in = 0; cyc(8);
    chk("R10 still armed", {7'b0, ctl_rdata[4]}, 8'h01);
    ext_in = 1; cyc(12); ext_in = 0; cyc(6);
    chk("R10 finished", {7'b0, ctl_rdata[4]}, 8'h00);

    chk_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule